// File: doc/BRIEF.md
# Write-only two-wire switch control slave

This block is a target on a two-wire serial bus (I2C) that lets a bus master set a bank of eight routing-select bits. A fast system clock oversamples both bus lines through two-flop synchronizers. From those samples the block finds start and stop conditions and rising and falling clock edges. It shifts in bytes MSB first and acknowledges only write transfers addressed to its fixed 7-bit address. It also acknowledges each data byte that follows such an address.

Each complete data byte becomes the new value of the parallel control output. A transfer cut short by a stop or a repeated start leaves the output at the last whole byte, and the partial byte is dropped. A refused address makes the block ignore the bus until the next start or stop. The block never drives SCL. It drives SDA only through an active-high pull-low enable for an open-drain pad.

Top module: `i2c_route_ctrl`

## Requirements
- R1: During and right after reset, `route_o` is 8'h00 and `sda_pull_o` is 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. While the bus is idle with both lines high, `sda_pull_o` stays 0, and it is 0 after any stop.
- R3: An address byte acknowledges only when its upper seven bits (sent first, MSB first) equal `DEV_ADDR` and its eighth bit (R/W) is 0. `sda_pull_o` rises after SCL falls at the end of the eighth bit and falls after SCL falls at the end of the ninth bit.
- R4: An address byte that does not match, or has R/W = 1, is not acknowledged. The following bytes are then not acknowledged and do not change `route_o` until the next start or stop.
- R5: After a matched write address, each data byte is shifted in MSB first and acknowledged on its ninth clock. It is copied to `route_o` when SCL falls at the end of its eighth bit.
- R6: Several data bytes in one transfer each update `route_o` in turn, so the last complete one remains.
- R7: A stop in the middle of a data byte leaves `route_o` at the last complete byte.
- R8: A repeated start in the middle of a data byte returns the block to address reception without changing `route_o`. The address that follows is judged afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| route_o | output | 8 | Switch control bits, last complete data byte |

## Verification
The hardest situations to reach are the aborted byte and the repeated start that cuts into a data phase. In both, the bus changes state while the shift register holds a partial byte that must not reach the output. The bench models a bus master with a wired-AND SDA line. It stops after a few bits of a byte, or issues a start with SCL high partway through a byte, and then checks the output. After a repeated start it sends a foreign address and then a matching one, so that a stale address match would show up as an acknowledge.

// File: rtl/i2c_route_ctrl.sv
module i2c_route_ctrl #(
  parameter logic [6:0] DEV_ADDR = 7'h4A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] route_o
);
  localparam logic [1:0] S_IDLE = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2, S_SKIP = 2'd3;

  logic [2:0] scl_q, sda_q;
  logic [1:0] state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire scl_high  = scl_q[1] & scl_q[2];
  wire start_det = scl_high & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_high & ~sda_q[2] & sda_q[1];
  wire addr_hit  = (shreg[7:1] == DEV_ADDR) && !shreg[0];
  wire active    = (state == S_ADDR) || (state == S_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      sda_pull_o <= 1'b0;
      route_o    <= '0;
    end else if (start_det) begin
      state      <= S_ADDR;
      bit_cnt    <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      state      <= S_IDLE;
      sda_pull_o <= 1'b0;
    end else if (active) begin
      if (scl_rise && bit_cnt < 4'd8) begin
        shreg   <= {shreg[6:0], sda_q[1]};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_fall && bit_cnt == 4'd8) begin
        if (sda_pull_o) begin
          sda_pull_o <= 1'b0;
          bit_cnt    <= '0;
          if (state == S_ADDR) state <= S_DATA;
        end else if (state == S_DATA) begin
          sda_pull_o <= 1'b1;
          route_o    <= shreg;
        end else if (addr_hit) begin
          sda_pull_o <= 1'b1;
        end else begin
          state <= S_SKIP;
        end
      end
    end
endmodule

// File: rtl/i2c_route_ctrl_chk.sv
module i2c_route_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_o,
  input logic [7:0] route_o,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic [1:0] state
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (route_o == 8'h00 && !sda_pull_o));

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);

  assert_pull_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall));

  assert_release_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> $past(scl_fall || start_det || stop_det));

  assert_skip_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3) |-> !sda_pull_o);

  assert_route_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(route_o) |-> $past(scl_fall));

  assert_restart_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == 2'd1 && $stable(route_o)));
endmodule

bind i2c_route_ctrl i2c_route_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .route_o(route_o),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det), .state(state)
);

// File: tb/i2c_route_ctrl_bench.sv
module i2c_route_ctrl_bench;
  localparam int T = 20;
  localparam logic [6:0] ADDR = 7'h4A;
  // {addr7, rw, data, expect_ack, expect_route}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {7'h4A, 1'b0, 8'hA5, 1'b1, 8'hA5},
    {7'h4A, 1'b0, 8'h3C, 1'b1, 8'h3C},
    {7'h21, 1'b0, 8'hFF, 1'b0, 8'h3C},
    {7'h4A, 1'b1, 8'h00, 1'b0, 8'h3C},
    {7'h4A, 1'b0, 8'h00, 1'b1, 8'h00},
    {7'h4A, 1'b0, 8'hFF, 1'b1, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_o;
  logic [7:0] route_o;
  wire sda_line = sda_m & ~sda_pull_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  i2c_route_ctrl #(.DEV_ADDR(ADDR)) u_i2c_route_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .route_o(route_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(); repeat (T) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic do_stop();
    scl_m = 1'b0; sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl_m = 1'b0; sda_m = b[i]; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
    send_bits(b, 8);
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt();
    ack = sda_pull_o;
    scl_m = 1'b0; wt();
    rel = !sda_pull_o;
  endtask

  initial begin
    bit ack, rel;
    repeat (4) @(negedge clk);
    chk(route_o == 8'h00 && !sda_pull_o, "R1 reset state", route_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(route_o == 8'h00 && !sda_pull_o, "R1 after reset", route_o, 0);
    wt();
    chk(!sda_pull_o, "R2 idle no pull", sda_pull_o, 0);

    for (int v = 0; v < NV; v++) begin
      do_start();
      send_byte({VEC[v][24:18], VEC[v][17]}, ack, rel);
      chk(ack == VEC[v][8], "R3/R4 address ack", ack, VEC[v][8]);
      chk(rel, "R3 ack released", !rel, 0);
      send_byte(VEC[v][16:9], ack, rel);
      chk(ack == VEC[v][8], "R4/R5 data ack", ack, VEC[v][8]);
      do_stop();
      chk(route_o == VEC[v][7:0], "R4/R5 route value", route_o, VEC[v][7:0]);
      chk(!sda_pull_o, "R2 no pull after stop", sda_pull_o, 0);
    end

    // R6: three bytes in one transfer
    do_start();
    send_byte({ADDR, 1'b0}, ack, rel);
    send_byte(8'h11, ack, rel);
    chk(route_o == 8'h11, "R6 first byte", route_o, 8'h11);
    send_byte(8'h22, ack, rel);
    send_byte(8'h5A, ack, rel);
    chk(ack, "R6 third byte ack", ack, 1);
    do_stop();
    chk(route_o == 8'h5A, "R6 last byte kept", route_o, 8'h5A);

    // R7: stop after five bits of a data byte
    do_start();
    send_byte({ADDR, 1'b0}, ack, rel);
    send_bits(8'hC3, 5);
    do_stop();
    chk(route_o == 8'h5A, "R7 partial byte dropped", route_o, 8'h5A);

    // R8: repeated start mid byte, foreign address, then matching address
    do_start();
    send_byte({ADDR, 1'b0}, ack, rel);
    send_bits(8'h96, 3);
    do_start();
    chk(route_o == 8'h5A, "R8 route held at restart", route_o, 8'h5A);
    send_byte({7'h4B, 1'b0}, ack, rel);
    chk(!ack, "R8 foreign address refused", ack, 0);
    send_byte(8'h77, ack, rel);
    chk(route_o == 8'h5A, "R8 no update after refusal", route_o, 8'h5A);
    do_start();
    send_byte({ADDR, 1'b0}, ack, rel);
    chk(ack, "R8 matching address after restart", ack, 1);
    send_byte(8'h69, ack, rel);
    do_stop();
    chk(route_o == 8'h69, "R8 new byte after restart", route_o, 8'h69);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule